// File: doc/BRIEF.md
# Dual-Enable Multiplexing Data Latch

This block is a six-bit word latch with a two-way input choice. Each bit has its own two-input selector. One shared select line picks word A or word B for all bits, and a level-sensitive storage cell sits after each selector. The storage is open only when both hold inputs are low. While it is open, the output follows the chosen word and tracks every change on the data or on the select line. If either hold input goes high, the word present just before that moment is frozen, and further changes on the data and select inputs have no effect until the latch opens again.

An active-high clear acts at once, without any clock. While it is high, every output bit is zero, whatever the select and hold inputs are doing. If the clear drops while a hold input is still high, the output stays at zero until the latch next opens. The block suits a place that must hold a result steady while upstream logic settles, with two independent sources each able to request the freeze.

Top module: `dual_hold_mux_latch`

## Requirements
- R1: With `clr` low and both hold inputs low, `sel` = 1 makes `q` equal `word_a`.
- R2: With `clr` low and both hold inputs low, `sel` = 0 makes `q` equal `word_b`.
- R3: While open, a change on the chosen data word appears on `q` with no clock edge needed.
- R4: While open, a change on `sel` alone switches `q` to the other word.
- R5: `hold_a` high with `hold_b` low freezes `q`; changes on `word_a`, `word_b` and `sel` leave `q` unchanged.
- R6: `hold_b` high with `hold_a` low freezes `q` in the same way.
- R7: Both hold inputs high freeze `q` in the same way.
- R8: The frozen value is the selected word present just before the first hold input rose.
- R9: `clr` high drives all bits of `q` to 0 at once, even with both hold inputs low and data changing.
- R10: `clr` raised while frozen clears `q`. After `clr` falls with a hold input still high, `q` stays 0 until both hold inputs are low.
- R11: Selection is per bit from the shared `sel`, so mixed bit patterns in A and B appear unaltered, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clr | input | 1 | Asynchronous clear, active high, overrides all else |
| sel | input | 1 | Word choice: 1 picks `word_a`, 0 picks `word_b` |
| word_a | input | W (6) | First data word |
| word_b | input | W (6) | Second data word |
| hold_a | input | 1 | First freeze request, active high |
| hold_b | input | 1 | Second freeze request, active high |
| q | output | W (6) | Latched output word |

## Verification
The two words are driven with complementary and alternating bit patterns. This separates a correct per-bit choice from a swapped select, a stuck bit, or bits wired to the wrong word. The select line and the data are toggled with the latch open and again with it frozen by each hold input alone and by both. That shows whether the hold is a true OR of the two inputs, and that a frozen output ignores both data and select. A sweep over every combination of select, both holds and clear, on changing data, is compared against a model kept in the bench. It includes clear raised and released while frozen, which tells an asynchronous, overriding clear apart from one that loses to the hold.

// File: rtl/dhml_pkg.sv
package dhml_pkg;
  localparam int DEF_WIDTH = 6;
  localparam int N_HOLD    = 2;
endpackage

// File: rtl/dhml_hold_merge.sv
module dhml_hold_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic         open
);
  // any single request closes the storage
  always_comb open = ~(|req);
endmodule

// File: rtl/dhml_word_select.sv
module dhml_word_select #(
  parameter int W = 6
) (
  input  logic         pick_a,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] chosen
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign chosen[i] = pick_a ? in_a[i] : in_b[i];
  end
endmodule

// File: rtl/dhml_store_cell.sv
module dhml_store_cell (
  input  logic clr,
  input  logic open,
  input  logic d,
  output logic q
);
  // clear wins over transparency; otherwise pass when open, keep when shut
  always_latch begin
    if (clr)       q <= 1'b0;
    else if (open) q <= d;
  end
endmodule

// File: rtl/dual_hold_mux_latch.sv
module dual_hold_mux_latch
  import dhml_pkg::*;
#(
  parameter int W = DEF_WIDTH
) (
  input  logic         clr,
  input  logic         sel,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic         hold_a,
  input  logic         hold_b,
  output logic [W-1:0] q
);
  logic              open;
  logic [W-1:0]      chosen;
  logic [N_HOLD-1:0] hold_vec;

  assign hold_vec = {hold_b, hold_a};

  dhml_hold_merge #(.N(N_HOLD)) u_merge (
    .req  (hold_vec),
    .open (open)
  );

  dhml_word_select #(.W(W)) u_select (
    .pick_a (sel),
    .in_a   (word_a),
    .in_b   (word_b),
    .chosen (chosen)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    dhml_store_cell u_cell (
      .clr  (clr),
      .open (open),
      .d    (chosen[i]),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/dhml_chk.sv
module dhml_chk #(
  parameter int W = 6
) (
  input logic         clr,
  input logic         sel,
  input logic [W-1:0] word_a,
  input logic [W-1:0] word_b,
  input logic         hold_a,
  input logic         hold_b,
  input logic [W-1:0] q
);
  logic         see_open;
  logic [W-1:0] shadow;

  assign see_open = !hold_a && !hold_b;

  // checker-side record of the output, taken while it may legally move
  always_latch begin
    if (clr || see_open) shadow <= q;
  end

  always_comb begin
    // R9
    if (clr) begin
      clear_zero_chk: assert (q == '0) else $error("clear did not zero the output");
    end
    // R1
    if (!clr && see_open && sel) begin
      pass_a_chk: assert (q == word_a) else $error("open latch not showing word A");
    end
    // R2
    if (!clr && see_open && !sel) begin
      pass_b_chk: assert (q == word_b) else $error("open latch not showing word B");
    end
    // R5 R6 R7 R10
    if (!clr && !see_open) begin
      frozen_keep_chk: assert (q == shadow) else $error("frozen output moved");
    end
  end
endmodule

bind dual_hold_mux_latch dhml_chk #(.W(W)) u_chk (
  .clr    (clr),
  .sel    (sel),
  .word_a (word_a),
  .word_b (word_b),
  .hold_a (hold_a),
  .hold_b (hold_b),
  .q      (q)
);

// File: tb/sim_dual_hold_mux_latch.sv
module sim_dual_hold_mux_latch;
  localparam int W = 6;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic         sel = 1'b0;
  logic [W-1:0] word_a = '0;
  logic [W-1:0] word_b = '0;
  logic         hold_a = 1'b0;
  logic         hold_b = 1'b0;
  logic [W-1:0] q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [W-1:0] model_q = '0;

  // 4 time units per period (250 MHz at 1 ns units)
  always #2 clk = ~clk;

  dual_hold_mux_latch #(.W(W)) u0 (
    .clr(clr), .sel(sel), .word_a(word_a), .word_b(word_b),
    .hold_a(hold_a), .hold_b(hold_b), .q(q)
  );

  task automatic chk(input string tag, input logic [W-1:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q actual=%b expected=%b", tag, q, exp);
    end
  endtask

  // apply one input set after a rising edge, update model, settle to falling edge
  task automatic drive(input logic s, input logic ha, input logic hb, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #1;
    sel = s; hold_a = ha; hold_b = hb; clr = c; word_a = a; word_b = b;
    if (c) model_q = '0;
    else if (!ha && !hb) model_q = s ? a : b;
    @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic t_reset;
    drive(1, 0, 0, 1, 6'b101101, 6'b010010);
    chk("R9 clear with latch open", '0);
    drive(0, 0, 0, 1, 6'b111111, 6'b111111);
    chk("R9 clear while data changes", '0);
  endtask

  task automatic t_select;
    drive(1, 0, 0, 0, 6'b101010, 6'b010101);
    chk("R1 sel=1 passes A", 6'b101010);
    drive(0, 0, 0, 0, 6'b101010, 6'b010101);
    chk("R2 sel=0 passes B", 6'b010101);
    drive(1, 0, 0, 0, 6'b110001, 6'b001110);
    chk("R11 mixed pattern from A", 6'b110001);
    drive(0, 0, 0, 0, 6'b110001, 6'b001110);
    chk("R11 mixed pattern from B", 6'b001110);
  endtask

  task automatic t_follow;
    drive(1, 0, 0, 0, 6'b000111, 6'b111000);
    drive(1, 0, 0, 0, 6'b011100, 6'b111000);
    chk("R3 open follows data", 6'b011100);
    drive(0, 0, 0, 0, 6'b011100, 6'b111000);
    chk("R4 open follows sel", 6'b111000);
  endtask

  task automatic t_hold(input logic ha, input logic hb, input string tag);
    drive(1, 0, 0, 0, 6'b100110, 6'b011001);
    drive(1, ha, hb, 0, 6'b100110, 6'b011001);
    chk({tag, " freeze entered"}, 6'b100110);
    drive(1, ha, hb, 0, 6'b000000, 6'b111111);
    chk({tag, " data change ignored"}, 6'b100110);
    drive(0, ha, hb, 0, 6'b000000, 6'b111111);
    chk({tag, " sel change ignored"}, 6'b100110);
    drive(0, 0, 0, 0, 6'b000000, 6'b111111);
    chk({tag, " reopen shows B"}, 6'b111111);
  endtask

  task automatic t_capture;
    drive(0, 0, 0, 0, 6'b111111, 6'b001011);
    // hold rises in the same step as new data: captured value is the old choice
    @(posedge clk);
    #1;
    hold_a = 1'b1;
    #1;
    word_b = 6'b110100;
    sel = 1'b1;
    @(negedge clk);
    chk("R8 value before hold rise kept", 6'b001011);
    drive(1, 0, 0, 0, 6'b111111, 6'b110100);
    chk("R8 reopen follows again", 6'b111111);
  endtask

  task automatic t_clr_hold;
    drive(1, 0, 0, 0, 6'b011011, 6'b100100);
    drive(1, 0, 1, 0, 6'b011011, 6'b100100);
    chk("R10 frozen before clear", 6'b011011);
    drive(1, 0, 1, 1, 6'b011011, 6'b100100);
    chk("R10 clear while frozen", '0);
    drive(1, 0, 1, 0, 6'b011011, 6'b100100);
    chk("R10 zero kept after clear release", '0);
    drive(0, 1, 1, 0, 6'b111111, 6'b111111);
    chk("R10 zero kept under both holds", '0);
    drive(0, 0, 0, 0, 6'b111111, 6'b010110);
    chk("R10 reopen after clear", 6'b010110);
    // clear pulse between clock edges with latch open
    @(posedge clk);
    #1;
    clr = 1'b1;
    #0.5;
    chk("R9 clear acts without clock", '0);
    clr = 1'b0;
    @(negedge clk);
    chk("R9 open after clear pulse", 6'b010110);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 64; i++) begin
      logic [3:0] c;
      logic [W-1:0] a;
      logic [W-1:0] b;
      string tag;
      c = i[3:0];
      a = W'((i * 13 + 5) & int'(ONES));
      b = W'((i * 29 + 17) & int'(ONES));
      drive(c[0], c[1], c[2], c[3], a, b);
      if (c[3]) tag = "R9 sweep clear";
      else if (c[1] && c[2]) tag = "R7 sweep both holds";
      else if (c[1]) tag = "R5 sweep hold_a";
      else if (c[2]) tag = "R6 sweep hold_b";
      else if (c[0]) tag = "R1 sweep pass A";
      else tag = "R2 sweep pass B";
      chk(tag, model_q);
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all requirements: actual=hung expected=finished");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_select();
    t_follow();
    t_hold(1, 0, "R5");
    t_hold(0, 1, "R6");
    t_hold(1, 1, "R7");
    t_capture();
    t_clr_hold();
    t_sweep();
    report();
  end
endmodule